// File: doc/BRIEF.md
# Dual-Preset Seconds Countdown Timer

This block is a moderator timer that counts down whole seconds. Two start buttons each load a fixed preset: a long one of 20 seconds and a short one of 5 seconds. While it runs, the count drops by one on every one-per-second enable tick. The tick comes from a separate divider, and on a 100 MHz system clock it is high for one cycle in every 100,000,000. The count is held as packed BCD, so a display decoder can use it directly.

A counter-active flag tells the display that the digits are valid. When the count reaches zero, a time-up flag rises and can enable an alarm tone. Time-up stays high until the timer is reset or a new start button is pressed.

The block carries no data stream. Every pin is a plain level or pulse control or status signal, so there is no valid/ready handshake and no back-pressure.

Top module: `dual_preset_countdown`

## Requirements
- R1: While `rst_ni` is low, and from then until the first start, `count_bcd_o` is 0x00 and both `active_o` and `timeup_o` are low. The reset is asynchronous, active low.
- R2: When `active_o` is low and `start_long_i` is high at a clock edge, that edge loads 0x20 (tens in bits 7:4, units in bits 3:0), sets `active_o` and clears `timeup_o`.
- R3: When `active_o` is low and only `start_short_i` is high at a clock edge, that edge loads 0x05, sets `active_o` and clears `timeup_o`.
- R4: When both start inputs are high in the same cycle, the 20-second preset is loaded.
- R5: Each edge with `tick_i` high while `active_o` is high decrements the count by one in BCD. The units digit wraps from 0 to 9 and borrows from the tens digit (0x10 becomes 0x09), and every nibble stays in the range 0 to 9.
- R6: While `active_o` is high and `tick_i` is low, the count does not change.
- R7: The tick that moves the count from 0x01 to 0x00 also clears `active_o` and sets `timeup_o` at the same edge. The count never goes below zero.
- R8: After the count reaches zero, `timeup_o` stays high and the count stays 0x00 until reset or a start. A start at that point reloads its preset and clears `timeup_o`.
- R9: Start inputs are ignored while `active_o` is high. A tick in the same cycle still decrements normally.
- R10: A tick is ignored while `active_o` is low, and also in a cycle where a start is accepted. In that cycle the preset itself is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse once per second |
| start_long_i | input | 1 | Start from the 20-second preset |
| start_short_i | input | 1 | Start from the 5-second preset |
| count_bcd_o | output | 8 | Remaining seconds, two packed BCD digits |
| active_o | output | 1 | Timer running; display digits valid |
| timeup_o | output | 1 | Count has reached zero; alarm enable |

## Verification
Every result is registered. A start or a tick shows on the count and both flags exactly one rising edge after the cycle in which it is presented, and a reset shows at once. The bench changes inputs just after a falling edge, lets one rising edge pass, and samples at the next falling edge, so each check lands in the cycle where its result first appears. Reset is checked a nanosecond after it is driven low, with no edge in between.

// File: rtl/countdown_pkg.sv
package countdown_pkg;

  typedef enum logic [1:0] {
    CD_IDLE = 2'd0,
    CD_RUN  = 2'd1,
    CD_DONE = 2'd2
  } cd_state_e;

  // Packs a binary seconds value into BCD nibbles, low digit in bits 3:0.
  function automatic logic [31:0] secs_to_bcd(input int unsigned secs);
    logic [31:0] r;
    int unsigned v;
    r = '0;
    v = secs;
    for (int i = 0; i < 8; i++) begin
      r[4*i +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

endpackage

// File: rtl/cd_start_select.sv
module cd_start_select (
  input  logic start_long_i,
  input  logic start_short_i,
  input  logic allow_i,
  output logic load_o,
  output logic pick_long_o
);
  // The long preset wins a tie (R4).
  assign load_o      = allow_i && (start_long_i || start_short_i);
  assign pick_long_o = start_long_i;
endmodule

// File: rtl/cd_bcd_digit.sv
module cd_bcd_digit (
  input  logic [3:0] digit_i,
  input  logic       borrow_i,
  output logic [3:0] digit_o,
  output logic       borrow_o
);
  always_comb begin
    digit_o  = digit_i;
    borrow_o = 1'b0;
    if (borrow_i) begin
      if (digit_i == 4'd0) begin
        digit_o  = 4'd9;
        borrow_o = 1'b1;
      end else begin
        digit_o = digit_i - 4'd1;
      end
    end
  end

  // A valid decimal digit in gives a valid decimal digit out.
  always_comb begin
    if (digit_i <= 4'd9) begin
      p_digit_range_r5: assert (digit_o <= 4'd9);
    end
  end
endmodule

// File: rtl/dual_preset_countdown.sv
module dual_preset_countdown #(
  parameter int unsigned DIGITS        = 2,
  parameter int unsigned LONG_SECONDS  = 20,
  parameter int unsigned SHORT_SECONDS = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                start_long_i,
  input  logic                start_short_i,
  output logic [4*DIGITS-1:0] count_bcd_o,
  output logic                active_o,
  output logic                timeup_o
);
  import countdown_pkg::*;

  localparam int unsigned CW = 4 * DIGITS;
  localparam logic [31:0] LONG_FULL  = secs_to_bcd(LONG_SECONDS);
  localparam logic [31:0] SHORT_FULL = secs_to_bcd(SHORT_SECONDS);
  localparam logic [CW-1:0] LONG_BCD  = LONG_FULL[CW-1:0];
  localparam logic [CW-1:0] SHORT_BCD = SHORT_FULL[CW-1:0];
  localparam logic [CW-1:0] ONE_BCD   = CW'(1);

  cd_state_e     state_q;
  logic [CW-1:0] count_q;
  logic [CW-1:0] count_dec;
  logic [DIGITS:0] borrow;
  logic          load, pick_long, dec, last;

  cd_start_select u_sel (
    .start_long_i (start_long_i),
    .start_short_i(start_short_i),
    .allow_i      (state_q != CD_RUN),
    .load_o       (load),
    .pick_long_o  (pick_long)
  );

  assign borrow[0] = 1'b1;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    cd_bcd_digit u_dig (
      .digit_i (count_q[4*g +: 4]),
      .borrow_i(borrow[g]),
      .digit_o (count_dec[4*g +: 4]),
      .borrow_o(borrow[g+1])
    );
  end

  assign dec  = (state_q == CD_RUN) && tick_i;
  assign last = (count_q == ONE_BCD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CD_IDLE;
      count_q <= '0;
    end else if (load) begin
      state_q <= CD_RUN;
      count_q <= pick_long ? LONG_BCD : SHORT_BCD;
    end else if (dec) begin
      count_q <= count_dec;
      if (last) state_q <= CD_DONE;
    end
  end

  assign count_bcd_o = count_q;
  assign active_o    = (state_q == CD_RUN);
  assign timeup_o    = (state_q == CD_DONE);

  // R2: a start of the long preset from rest loads it.
  p_load_long_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_o && start_long_i) |=> (count_bcd_o == LONG_BCD && active_o && !timeup_o));

  // R3: the short preset alone loads the short value.
  p_load_short_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_o && start_short_i && !start_long_i) |=> (count_bcd_o == SHORT_BCD && active_o));

  // R6 and R9: a running count without a tick holds, whatever the start pins do.
  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !tick_i) |=> ($stable(count_bcd_o) && active_o));

  // R7: a running decrement never borrows out of the top digit.
  p_no_underflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec |-> !borrow[DIGITS]);

  // R8: time-up latches at zero until a start.
  p_timeup_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeup_o && !start_long_i && !start_short_i) |=> (timeup_o && count_bcd_o == '0));

  // R10: at rest, a tick alone changes nothing.
  p_idle_tick_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_o && !start_long_i && !start_short_i) |=> ($stable(count_bcd_o) && !active_o));
endmodule

// File: tb/dual_preset_countdown_tb_top.sv
module dual_preset_countdown_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       s_long = 1'b0;
  logic       s_short = 1'b0;
  logic [7:0] count;
  logic       active, timeup;
  int         checks = 0;
  int         failures = 0;

  always #2 clk = ~clk;  // 250 MHz

  dual_preset_countdown dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .tick_i       (tick),
    .start_long_i (s_long),
    .start_short_i(s_short),
    .count_bcd_o  (count),
    .active_o     (active),
    .timeup_o     (timeup)
  );

  // Vector: {long, short, tick, req[3:0], count[7:0], active, timeup}
  localparam int NV = 18;
  localparam logic [16:0] VEC [NV] = '{
    {3'b010, 4'd3,  8'h05, 2'b10},  // R3 short start
    {3'b001, 4'd5,  8'h04, 2'b10},  // R5 tick
    {3'b000, 4'd6,  8'h04, 2'b10},  // R6 no tick holds
    {3'b100, 4'd9,  8'h04, 2'b10},  // R9 long ignored while running
    {3'b011, 4'd9,  8'h03, 2'b10},  // R9 short ignored, tick counts
    {3'b001, 4'd5,  8'h02, 2'b10},  // R5
    {3'b001, 4'd5,  8'h01, 2'b10},  // R5
    {3'b001, 4'd7,  8'h00, 2'b01},  // R7 reach zero
    {3'b001, 4'd10, 8'h00, 2'b01},  // R10 tick at rest ignored
    {3'b000, 4'd8,  8'h00, 2'b01},  // R8 time-up held
    {3'b010, 4'd8,  8'h05, 2'b10},  // R8 restart clears time-up
    {3'b001, 4'd5,  8'h04, 2'b10},  // R5
    {3'b001, 4'd5,  8'h03, 2'b10},  // R5
    {3'b001, 4'd5,  8'h02, 2'b10},  // R5
    {3'b001, 4'd5,  8'h01, 2'b10},  // R5
    {3'b001, 4'd7,  8'h00, 2'b01},  // R7
    {3'b111, 4'd4,  8'h20, 2'b10},  // R4 both starts, tick ignored
    {3'b001, 4'd5,  8'h19, 2'b10}   // R5 borrow 20 -> 19
  };

  task automatic check(input string tag, input logic [7:0] c_exp,
                       input logic a_exp, input logic t_exp);
    checks++;
    if (count !== c_exp || active !== a_exp || timeup !== t_exp) begin
      failures++;
      $display("FAIL %s: got count=%h active=%b timeup=%b, expected count=%h active=%b timeup=%b",
               tag, count, active, timeup, c_exp, a_exp, t_exp);
    end
  endtask

  // Drive just after a falling edge; one rising edge passes; return at the next falling edge.
  task automatic cyc(input logic l, input logic s, input logic t);
    s_long = l; s_short = s; tick = t;
    @(negedge clk);
    s_long = 1'b0; s_short = 1'b0; tick = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog: got no finish, expected finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 during reset", 8'h00, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", 8'h00, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i][16], VEC[i][15], VEC[i][14]);
      check($sformatf("R%0d vector %0d", VEC[i][13:10], i), VEC[i][9:2], VEC[i][1], VEC[i][0]);
    end

    // R5: borrow across the tens digit, 19 down to 10 then 09.
    for (int i = 0; i < 9; i++) cyc(1'b0, 1'b0, 1'b1);
    check("R5 reach 10", 8'h10, 1'b1, 1'b0);
    cyc(1'b0, 1'b0, 1'b1);
    check("R5 borrow 10->09", 8'h09, 1'b1, 1'b0);
    for (int i = 0; i < 8; i++) cyc(1'b0, 1'b0, 1'b1);
    check("R7 one left", 8'h01, 1'b1, 1'b0);
    cyc(1'b0, 1'b0, 1'b1);
    check("R7 zero from long", 8'h00, 1'b0, 1'b1);
    cyc(1'b0, 1'b0, 1'b0);
    check("R8 held", 8'h00, 1'b0, 1'b1);

    // R1: asynchronous reset in mid-run.
    cyc(1'b1, 1'b0, 1'b0);
    check("R2 long from time-up", 8'h20, 1'b1, 1'b0);
    cyc(1'b0, 1'b0, 1'b1);
    #1 rst_n = 1'b0;
    #1 check("R1 async mid-run", 8'h00, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: tick at rest, and tick alongside an accepted start.
    cyc(1'b0, 1'b0, 1'b1);
    check("R10 idle tick", 8'h00, 1'b0, 1'b0);
    cyc(1'b0, 1'b1, 1'b1);
    check("R10 tick with short start", 8'h05, 1'b1, 1'b0);
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b0, 1'b1);
    check("R7 short run ends", 8'h00, 1'b0, 1'b1);
    cyc(1'b1, 1'b0, 1'b0);
    check("R2 long after short", 8'h20, 1'b1, 1'b0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule